// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer and marks the end of each divide period with a pulse for a phase comparator. A prescaler stage counts either ten or eleven input cycles per step. A main counter counts those steps. A swallow counter keeps the prescaler on its long (eleven) modulus for the first few steps of every period, and after that the prescaler uses its short (ten) modulus.

The whole block runs on the input clock itself and holds no other timing reference. A single 13-bit control word carries both counts. It is sampled only when a period starts, so software or a configuration path may change it at any moment without corrupting the period in flight. A direct mode takes the prescaler out of the path, and the main counter then counts raw input cycles. This gives low divide ratios for low input frequencies.

Top module: `fm_feedback_divider`

## Requirements
- R1: With `direct_mode` low, the main count M is `div_word[12:4]` and the swallow count A is `div_word[3:0]`. Provided A <= M, the interval between consecutive `cmp_pulse` assertions is 10*(M+1)+A input clock cycles.
- R2: `cmp_pulse` is high for exactly one input clock cycle per period whenever the period is longer than one cycle.
- R3: The prescaler runs its eleven-cycle modulus for the first A steps of a period and its ten-cycle modulus for the rest. As a result, A = 0 gives an exact multiple of ten, 10*(M+1), and A = M gives 11*M+10.
- R4: With `direct_mode` high, the period is M+1 input cycles and the swallow field has no effect on it.
- R5: A change of `div_word` inside a period leaves that period's length unchanged. The new value governs every period that starts after the next `cmp_pulse`.
- R6: While `rst` is high (synchronous, active high), `cmp_pulse` is low and both counts reload from `div_word`. After `rst` falls, the first pulse appears after exactly one full period, even if the reset cut a period short.
- R7: The extreme prescaled settings hold the R1 formula: M = 1 gives 20 or 21 cycles, and M = 511 with A = 15 gives 5135 cycles.
- R8: In direct mode, M = 0 keeps `cmp_pulse` high on every cycle, and M = 511 gives a period of 512 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided (the oscillator side) |
| rst | input | 1 | Synchronous active-high reset that restarts division |
| div_word | input | 13 | Divide control: main count in bits 12:4, swallow count in bits 3:0 |
| direct_mode | input | 1 | High removes the prescaler; the main counter counts input cycles |
| cmp_pulse | output | 1 | One-cycle pulse at the end of each divide period |

## Verification
The bench builds the block with its default widths: a 9-bit main count, a 4-bit swallow count and a short modulus of ten. Those defaults reach the largest settings of both counts, including the 5135-cycle period and the swallow count equal to the main count. A scoreboard holds the expected length of every period and checks it against the measured spacing of the pulses. The same scoreboard covers mid-period word changes, a reset that cuts a period short, and the direct mode down to the one-cycle period.

// File: rtl/fmdiv_pkg.sv
package fmdiv_pkg;

    // Field widths of the divide control word
    localparam int DEF_MAIN_W    = 9;
    localparam int DEF_SWAL_W    = 4;
    // Short prescaler modulus; the long one is one more
    localparam int DEF_PRE_SHORT = 10;

    typedef enum logic {
        MODE_PRESCALED = 1'b0,
        MODE_DIRECT    = 1'b1
    } div_mode_e;

    function automatic div_mode_e mode_of(input logic direct);
        return direct ? MODE_DIRECT : MODE_PRESCALED;
    endfunction

endpackage

// File: rtl/mod_prescaler.sv
module mod_prescaler
    import fmdiv_pkg::*;
#(
    parameter int PRE_SHORT = DEF_PRE_SHORT
) (
    input  logic      clk,
    input  logic      rst,
    input  div_mode_e mode,
    input  logic      long_next,
    output logic      step
);
    localparam int PC_W = $clog2(PRE_SHORT + 1);
    localparam logic [PC_W-1:0] LOAD_LONG  = PC_W'(PRE_SHORT);
    localparam logic [PC_W-1:0] LOAD_SHORT = PC_W'(PRE_SHORT - 1);
    localparam logic [PC_W-1:0] PC_ONE     = PC_W'(1);

    logic [PC_W-1:0] cnt_q;

    // A step ends whenever the countdown is spent; in direct mode every cycle is a step
    assign step = (mode == MODE_DIRECT) || (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || step) begin
            cnt_q <= long_next ? LOAD_LONG : LOAD_SHORT;
        end else begin
            cnt_q <= cnt_q - PC_ONE;
        end
    end

    // R3: after a step the countdown restarts at one of the two moduli
    a_r3_modulus_load: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PRESCALED && cnt_q == '0) |=> (cnt_q == LOAD_LONG || cnt_q == LOAD_SHORT));

    // R3: inside a step the countdown falls by one per input cycle
    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PRESCALED && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - PC_ONE));

endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
    import fmdiv_pkg::*;
#(
    parameter int MAIN_W = DEF_MAIN_W,
    parameter int SWAL_W = DEF_SWAL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  div_mode_e         mode,
    input  logic              step,
    input  logic [MAIN_W-1:0] main_load,
    input  logic [SWAL_W-1:0] swal_load,
    output logic              long_next,
    output logic              term
);
    localparam logic [MAIN_W-1:0] MAIN_ONE = MAIN_W'(1);
    localparam logic [SWAL_W-1:0] SWAL_ONE = SWAL_W'(1);

    logic [MAIN_W-1:0] main_q, main_d;
    logic [SWAL_W-1:0] swal_q, swal_d;

    assign term = step && (main_q == '0);

    always_comb begin
        main_d = main_q;
        swal_d = swal_q;
        if (rst || term) begin
            main_d = main_load;
            swal_d = swal_load;
        end else if (step) begin
            main_d = main_q - MAIN_ONE;
            swal_d = (swal_q != '0) ? swal_q - SWAL_ONE : swal_q;
        end
    end

    // The prescaler stays on the long modulus while swallow steps remain
    assign long_next = (swal_d != '0);

    always_ff @(posedge clk) begin
        main_q <= main_d;
        swal_q <= swal_d;
    end

    // R5: a new period takes the counts present at its boundary
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        term |=> (main_q == $past(main_load) && swal_q == $past(swal_load)));

    // R4: in direct mode the main count falls every input cycle
    a_r4_direct_step: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DIRECT && main_q != '0) |=> (main_q == $past(main_q) - MAIN_ONE));

    // R3: swallow steps are used up before the main count runs out (given A <= M)
    a_r3_swallow_first: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PRESCALED && step && swal_q != '0) |-> (main_q != '0));

endmodule

// File: rtl/fm_feedback_divider.sv
module fm_feedback_divider
    import fmdiv_pkg::*;
#(
    parameter int MAIN_W    = DEF_MAIN_W,
    parameter int SWAL_W    = DEF_SWAL_W,
    parameter int PRE_SHORT = DEF_PRE_SHORT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [MAIN_W+SWAL_W-1:0] div_word,
    input  logic                     direct_mode,
    output logic                     cmp_pulse
);
    localparam int WORD_W = MAIN_W + SWAL_W;

    div_mode_e         mode;
    logic              step;
    logic              long_next;
    logic              term;
    logic [MAIN_W-1:0] main_load;
    logic [SWAL_W-1:0] swal_load;
    logic              pulse_q;

    assign mode      = mode_of(direct_mode);
    assign main_load = div_word[WORD_W-1:SWAL_W];
    assign swal_load = div_word[SWAL_W-1:0];

    mod_prescaler #(
        .PRE_SHORT (PRE_SHORT)
    ) u_presc (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .long_next (long_next),
        .step      (step)
    );

    swallow_ctrl #(
        .MAIN_W (MAIN_W),
        .SWAL_W (SWAL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .step      (step),
        .main_load (main_load),
        .swal_load (swal_load),
        .long_next (long_next),
        .term      (term)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= term;
        end
    end

    assign cmp_pulse = pulse_q;

    // R2: in prescaled mode a pulse never lasts two cycles
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (cmp_pulse && !direct_mode) |=> !cmp_pulse);

    // R6: the cycle after a reset edge shows no pulse
    a_r6_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !cmp_pulse);

endmodule

// File: tb/test_fm_feedback_divider.sv
module test_fm_feedback_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] div_word = '0;
    logic        direct_mode = 1'b0;
    logic        cmp_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    fm_feedback_divider i_fm_feedback_divider (
        .clk         (clk),
        .rst         (rst),
        .div_word    (div_word),
        .direct_mode (direct_mode),
        .cmp_pulse   (cmp_pulse)
    );

    function automatic int ratio(input int m, input int a, input bit direct);
        return direct ? (m + 1) : (10 * (m + 1) + a);
    endfunction

    // Monitor: measures pulse spacing and checks it against the scoreboard
    int cnt = 0;
    bit chk_low = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            cnt = 0;
            chk_low = 1'b0;
            checks++;
            if (cmp_pulse !== 1'b0) begin
                errors++;
                $display("FAIL R6: pulse during reset actual=%b expected=0", cmp_pulse);
            end
        end else begin
            cnt++;
            if (chk_low) begin
                chk_low = 1'b0;
                checks++;
                if (cmp_pulse !== 1'b0) begin
                    errors++;
                    $display("FAIL R2: pulse wider than one cycle actual=%b expected=0", cmp_pulse);
                end
            end
            if (cmp_pulse === 1'b1) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2: unexpected pulse after %0d cycles actual=1 expected=0", cnt);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (cnt != e) begin
                        errors++;
                        $display("FAIL %s: period actual=%0d expected=%0d", t, cnt, e);
                    end
                    chk_low = (e > 1);
                end
                cnt = 0;
            end
        end
    end

    task automatic push(input int e, input string t, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) begin
            @(negedge clk);
            #2;
        end
        rst = 1'b1;
    endtask

    // Driver: reset with a setting, queue the expected periods, wait for them
    task automatic run_cfg(input int m, input int a, input bit direct, input int n, input string t);
        rst = 1'b1;
        div_word = {9'(m), 4'(a)};
        direct_mode = direct;
        push(ratio(m, a, direct), t, n);
        repeat (2) @(negedge clk);
        #1 rst = 1'b0;
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        run_cfg(3, 2, 1'b0, 3, "R1");        // 42
        run_cfg(15, 15, 1'b0, 2, "R3");      // swallow equal to main: 175
        run_cfg(9, 0, 1'b0, 2, "R3");        // multiple of ten: 100
        run_cfg(1, 1, 1'b0, 3, "R7");        // 21
        run_cfg(1, 0, 1'b0, 3, "R7");        // 20
        run_cfg(511, 15, 1'b0, 2, "R7");     // 5135
        run_cfg(5, 3, 1'b1, 4, "R4");        // swallow ignored: 6
        run_cfg(0, 9, 1'b1, 6, "R8");        // every cycle
        run_cfg(511, 0, 1'b1, 2, "R8");      // 512

        // R5: change word inside the first period
        rst = 1'b1;
        direct_mode = 1'b0;
        div_word = {9'd4, 4'd1};
        push(ratio(4, 1, 1'b0), "R5", 1);
        push(ratio(2, 2, 1'b0), "R5", 2);
        repeat (2) @(negedge clk);
        #1 rst = 1'b0;
        repeat (10) @(negedge clk);
        #1 div_word = {9'd2, 4'd2};
        drain();

        // R6: reset cuts a period short, then a full period follows release
        div_word = {9'd6, 4'd3};
        repeat (2) @(negedge clk);
        #1 rst = 1'b0;
        repeat (30) @(negedge clk);
        #1 rst = 1'b1;
        push(ratio(6, 3, 1'b0), "R6", 2);
        repeat (2) @(negedge clk);
        #1 rst = 1'b0;
        drain();

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 200000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles actual=%0d expected<200000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule